// File: doc/BRIEF.md
# Serial Register Access Port

This block is a chip-select framed serial slave that lets a host processor read and write a bank of eleven 8-bit registers. Nine of the registers hold control and configuration values. The other two hold status bits that line-monitoring logic sets in a separate line clock domain. Each transfer opens with a command byte. One or more data bytes follow it. All bytes travel least significant bit first on `sdi` and `sdo`, timed by `sclk`. A burst command steps through the whole bank in address order, one byte per register.

The serial side runs entirely on `sclk` and is held in reset whenever `cs_n` is high. Port accesses therefore do not depend on the line clock. The status registers are the one exception. A single-register read of a status register asks the line clock domain to clear it. The request crosses through a toggle synchronizer, so the clear takes effect only while `lclk` runs. A burst read polls both status registers and leaves them unchanged. The serial data output has a separate enable, `sdo_enable`, for a tri-state pad driver. Because the enable stays low during writes, `sdo` and `sdi` can share one bidirectional host pin.

Top module: `serial_reg_port`

## Requirements
- R1: The command byte is the first 8 bits clocked in after `cs_n` falls. Its bit 0 is the direction (0 = write, 1 = read) and bits 4:1 are the register address. A write stores the next 8 bits, taken LSB first, into the addressed register. Register n appears on `cfg_regs[8n+7:8n]`.
- R2: After a read command, `sdo` presents the addressed register LSB first. Each bit changes on a falling `sclk` edge and is valid at the following rising edge. `sdo_enable` is high for the whole data byte.
- R3: Addresses 0 to 8 are read/write configuration registers. Address 9 is status register 1 and address 10 is status register 2. Both status registers are read-only. Addresses 11 to 15 read as 0x00. Writes to addresses 9 to 15 change nothing.
- R4: A command byte with bit 5 or bit 6 set voids the transfer. No register is written, no status register is cleared, and `sdo_enable` stays low.
- R5: A command byte with bit 7 set and address 0 starts a burst. Successive data bytes go to, or come from, registers 0, 1, … 10 in order. Bytes after register 10 are ignored, and `sdo_enable` is low for them. With a nonzero address, bit 7 has no effect and the transfer is a single-register access.
- R6: `cs_n` high aborts a transfer at any point. A partly shifted byte is discarded, `sdo_enable` goes low, and the next low period of `cs_n` starts again with a command byte.
- R7: `sdo_enable` is low throughout every write transfer. It is also low during every command byte.
- R8: A single-register read of address 9 or 10 that completes its 8 bits clears that status register within 5 `lclk` cycles. A burst read clears neither status register.
- R9: Status bits are sticky. A bit rises only when its `stat1_set`/`stat2_set` input is high, and it stays set at least until a later clear. A set input that is high in the clearing cycle wins over the clear.
- R10: `rst_n` low clears all configuration and status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for registers and synchronizers |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; high resets the port logic |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| sdo | output | 1 | Serial data out, changes on falling `sclk` |
| sdo_enable | output | 1 | Drive enable for the `sdo` pad; low means tri-state |
| cfg_regs | output | 72 | Configuration registers 0 to 8, register n in bits 8n+7:8n |
| lclk | input | 1 | Line clock of the status domain |
| stat1_set | input | 8 | Per-bit set strobes for status register 1 (lclk domain) |
| stat2_set | input | 8 | Per-bit set strobes for status register 2 (lclk domain) |
| stat1 | output | 8 | Status register 1 (address 9) |
| stat2 | output | 8 | Status register 2 (address 10) |

## Verification
The bench sweeps all 256 data values through one register and writes and reads every one of the 16 addresses. A design with a reversed bit order, a misplaced address field or a wrong decode of the unused addresses fails these comparisons. Further cases cover a burst at address zero and a burst bit with a nonzero address, to catch a port that mis-handles bursts. They also cover reserved bits in the command byte and `cs_n` rising mid-byte, to catch a port that stores a partial or void byte or drives `sdo` during writes. On the status side, a single read must clear the register and a burst read must not. A set strobe held through the clearing cycle must survive, which catches a clear that overrides a simultaneous set.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int NUM_CFG = 9,
  parameter int SYNC    = 3
) (
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_enable,
  output logic [NUM_CFG*8-1:0] cfg_regs,
  input  logic                 lclk,
  input  logic [7:0]           stat1_set,
  input  logic [7:0]           stat2_set,
  output logic [7:0]           stat1,
  output logic [7:0]           stat2
);
  localparam logic [3:0] ST1_ADDR = 4'(NUM_CFG);
  localparam logic [3:0] ST2_ADDR = 4'(NUM_CFG + 1);

  logic [2:0] bcnt;
  logic [6:0] shreg;
  logic       in_data, rw, bad, burst, done;
  logic [3:0] addr;
  logic [7:0] cfg [NUM_CFG];
  logic [7:0] rdata, shadow;
  logic       sdo_q, clr1_t, clr2_t;

  wire [7:0] rx_byte  = {sdi, shreg};
  wire       byte_end = (bcnt == 3'd7);
  wire       active   = in_data && !bad && !done;
  wire       data_end = !cs_n && byte_end && active;

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      bcnt <= '0; shreg <= '0; in_data <= 1'b0; rw <= 1'b0;
      bad <= 1'b0; burst <= 1'b0; done <= 1'b0; addr <= '0;
    end else begin
      bcnt  <= bcnt + 3'd1;
      shreg <= {sdi, shreg[6:1]};
      if (byte_end) begin
        if (!in_data) begin
          in_data <= 1'b1;
          rw      <= rx_byte[0];
          addr    <= rx_byte[4:1];
          bad     <= rx_byte[5] | rx_byte[6];
          burst   <= rx_byte[7] && (rx_byte[4:1] == 4'd0);
        end else if (!burst || addr == ST2_ADDR) begin
          done <= 1'b1;
        end else begin
          addr <= addr + 4'd1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) cfg[g] <= '0;
      else if (data_end && !rw && addr == 4'(g)) cfg[g] <= rx_byte;
    end
    assign cfg_regs[g*8 +: 8] = cfg[g];
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      clr1_t <= 1'b0; clr2_t <= 1'b0;
    end else if (data_end && rw && !burst) begin
      if (addr == ST1_ADDR) clr1_t <= ~clr1_t;
      if (addr == ST2_ADDR) clr2_t <= ~clr2_t;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_CFG; i++)
      if (addr == 4'(i)) rdata = cfg[i];
    if (addr == ST1_ADDR) rdata = stat1;
    if (addr == ST2_ADDR) rdata = stat2;
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      sdo_enable <= 1'b0; sdo_q <= 1'b0; shadow <= '0;
    end else begin
      sdo_enable <= active && rw;
      if (bcnt == 3'd0) begin
        shadow <= rdata;
        sdo_q  <= rdata[0];
      end else begin
        sdo_q  <= shadow[bcnt];
      end
    end
  end
  assign sdo = sdo_q;

  logic [SYNC:0] s1q, s2q;
  wire clr1 = s1q[SYNC] ^ s1q[SYNC-1];
  wire clr2 = s2q[SYNC] ^ s2q[SYNC-1];

  always_ff @(posedge lclk or negedge rst_n) begin
    if (!rst_n) begin
      s1q <= '0; s2q <= '0; stat1 <= '0; stat2 <= '0;
    end else begin
      s1q   <= {s1q[SYNC-1:0], clr1_t};
      s2q   <= {s2q[SYNC-1:0], clr2_t};
      stat1 <= (stat1 & ~{8{clr1}}) | stat1_set;
      stat2 <= (stat2 & ~{8{clr2}}) | stat2_set;
    end
  end
endmodule

module serial_reg_port_chk #(
  parameter int NUM_CFG = 9
) (
  input logic                 rst_n,
  input logic                 lclk,
  input logic                 cs_n,
  input logic                 sdo_enable,
  input logic [NUM_CFG*8-1:0] cfg_regs,
  input logic [7:0]           stat1_set,
  input logic [7:0]           stat2_set,
  input logic [7:0]           stat1,
  input logic [7:0]           stat2
);
  p_sdo_off_idle_r6: assert property (@(posedge lclk) disable iff (!rst_n)
    cs_n |-> !sdo_enable);
  p_cfg_hold_idle_r1: assert property (@(posedge lclk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> $stable(cfg_regs));
  p_set_wins1_r9: assert property (@(posedge lclk) disable iff (!rst_n)
    (stat1_set != 8'h00) |=> ((stat1 & $past(stat1_set)) == $past(stat1_set)));
  p_set_wins2_r9: assert property (@(posedge lclk) disable iff (!rst_n)
    (stat2_set != 8'h00) |=> ((stat2 & $past(stat2_set)) == $past(stat2_set)));
  p_no_spurious1_r9: assert property (@(posedge lclk) disable iff (!rst_n)
    (stat1 & ~$past(stat1) & ~$past(stat1_set)) == 8'h00);
  p_no_spurious2_r9: assert property (@(posedge lclk) disable iff (!rst_n)
    (stat2 & ~$past(stat2) & ~$past(stat2_set)) == 8'h00);
endmodule

bind serial_reg_port serial_reg_port_chk #(.NUM_CFG(NUM_CFG)) u_chk (
  .rst_n(rst_n), .lclk(lclk), .cs_n(cs_n), .sdo_enable(sdo_enable),
  .cfg_regs(cfg_regs), .stat1_set(stat1_set), .stat2_set(stat2_set),
  .stat1(stat1), .stat2(stat2)
);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 20;
  localparam int NC = 9;

  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, lclk = 1'b0;
  logic [7:0] stat1_set = '0, stat2_set = '0;
  logic sdo, sdo_enable;
  logic [NC*8-1:0] cfg_regs;
  logic [7:0] stat1, stat2;

  serial_reg_port #(.NUM_CFG(NC)) dut_i (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .sdo_enable(sdo_enable), .cfg_regs(cfg_regs), .lclk(lclk),
    .stat1_set(stat1_set), .stat2_set(stat2_set), .stat1(stat1), .stat2(stat2)
  );

  always #(CLK_PERIOD/2) lclk = ~lclk;

  int checks = 0, fails = 0;
  logic [7:0] tx [16];
  logic [7:0] rx [16];
  logic       oe_all [16];
  logic       oe_any [16];
  logic       cmd_oe;
  logic [7:0] model [NC];

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd(input logic rd, input int a, input logic bst, input logic [1:0] res);
    return {bst, res, 4'(a), rd};
  endfunction

  task automatic send_bit(input logic b, output logic o, output logic oe);
    sdi = b; #(H/2); o = sdo; oe = sdo_enable; #(H/2) sclk = 1'b1; #(H) sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] c, input int nb);
    logic o, oe;
    cs_n = 1'b0; #(H); cmd_oe = 1'b0;
    for (int i = 0; i < 8; i++) begin send_bit(c[i], o, oe); cmd_oe |= oe; end
    for (int b = 0; b < nb; b++) begin
      oe_all[b] = 1'b1; oe_any[b] = 1'b0;
      for (int i = 0; i < 8; i++) begin
        send_bit(tx[b][i], o, oe);
        rx[b][i] = o; oe_all[b] &= oe; oe_any[b] |= oe;
      end
    end
    #(H) cs_n = 1'b1; #(H);
  endtask

  task automatic aborted(input logic [7:0] c, input int nbits);
    logic o, oe;
    cs_n = 1'b0; #(H);
    for (int i = 0; i < 8; i++) send_bit(c[i], o, oe);
    for (int i = 0; i < nbits; i++) send_bit(tx[0][i], o, oe);
    #(H) cs_n = 1'b1; #(H/2);
    check("R6 oe after abort", 72'(sdo_enable), 72'(0));
    #(H);
  endtask

  task automatic lwait(input int n);
    repeat (n) @(posedge lclk);
    #1;
  endtask

  task automatic check_cfg(input string req);
    for (int a = 0; a < NC; a++) check(req, 72'(cfg_regs[a*8 +: 8]), 72'(model[a]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < NC; a++) model[a] = 8'h00;
    lwait(4); #2;
    check("R10 cfg reset", 72'(cfg_regs), 72'(0));
    check("R10 stat reset", 72'({stat1, stat2}), 72'(0));
    check("R6 oe idle", 72'(sdo_enable), 72'(0));
    rst_n = 1'b1; lwait(2);

    // R1 R2 R7: full data sweep through register 0
    for (int v = 0; v < 256; v++) begin
      tx[0] = 8'(v);
      xfer(cmd(1'b0, 0, 1'b0, 2'b00), 1);
      check("R7 oe during write", 72'(oe_any[0] | cmd_oe), 72'(0));
      check("R1 write", 72'(cfg_regs[7:0]), 72'(v));
      xfer(cmd(1'b1, 0, 1'b0, 2'b00), 1);
      check("R2 read data", 72'(rx[0]), 72'(v));
      check("R2 oe during read", 72'({oe_all[0], cmd_oe}), 72'(2));
    end
    model[0] = 8'hFF;

    // R3: every address
    for (int a = 0; a < 16; a++) begin
      tx[0] = 8'(a * 29 + 3);
      xfer(cmd(1'b0, a, 1'b0, 2'b00), 1);
      if (a < NC) model[a] = 8'(a * 29 + 3);
    end
    check_cfg("R3 map after writes");
    check("R3 status read-only", 72'({stat1, stat2}), 72'(0));
    for (int a = 0; a < 16; a++) begin
      xfer(cmd(1'b1, a, 1'b0, 2'b00), 1);
      check("R3 read map", 72'(rx[0]), a < NC ? 72'(model[a]) : 72'(0));
    end

    // R4: reserved bits
    tx[0] = 8'hAA;
    xfer(cmd(1'b0, 2, 1'b0, 2'b01), 1);
    xfer(cmd(1'b0, 2, 1'b0, 2'b10), 1);
    check("R4 void write", 72'(cfg_regs[23:16]), 72'(model[2]));
    xfer(cmd(1'b1, 2, 1'b0, 2'b10), 1);
    check("R4 void read oe", 72'(oe_any[0]), 72'(0));

    // R5: burst write and read
    for (int b = 0; b < 12; b++) tx[b] = 8'(b * 17 + 100);
    xfer(cmd(1'b0, 0, 1'b1, 2'b00), 12);
    for (int a = 0; a < NC; a++) model[a] = 8'(a * 17 + 100);
    check_cfg("R5 burst write");
    check("R5 burst write status", 72'({stat1, stat2}), 72'(0));
    xfer(cmd(1'b1, 0, 1'b1, 2'b00), 12);
    for (int b = 0; b < 11; b++) begin
      check("R5 burst read", 72'(rx[b]), b < NC ? 72'(model[b]) : 72'(0));
      check("R5 burst oe", 72'(oe_all[b]), 72'(1));
    end
    check("R5 oe after last", 72'(oe_any[11]), 72'(0));
    tx[0] = 8'h5A; tx[1] = 8'hC3;
    xfer(cmd(1'b0, 3, 1'b1, 2'b00), 2);
    model[3] = 8'h5A;
    check_cfg("R5 burst bit nonzero addr");
    xfer(cmd(1'b1, 3, 1'b1, 2'b00), 2);
    check("R5 single read", 72'({rx[0], oe_any[1]}), 72'({8'h5A, 1'b0}));

    // R6: aborts
    tx[0] = 8'h0F;
    aborted(cmd(1'b0, 1, 1'b0, 2'b00), 4);
    check("R6 partial write dropped", 72'(cfg_regs[15:8]), 72'(model[1]));
    aborted(cmd(1'b1, 1, 1'b0, 2'b00), 3);
    tx[0] = 8'h77;
    xfer(cmd(1'b0, 1, 1'b0, 2'b00), 1);
    model[1] = 8'h77;
    check("R6 fresh transfer", 72'(cfg_regs[15:8]), 72'(model[1]));

    // R8: clear on single read only
    @(negedge lclk) stat1_set = 8'h3C;
    @(negedge lclk) stat1_set = 8'h00;
    lwait(1);
    check("R9 set", 72'(stat1), 72'(8'h3C));
    xfer(cmd(1'b1, NC, 1'b0, 2'b00), 1);
    check("R8 read status1", 72'(rx[0]), 72'(8'h3C));
    lwait(5);
    check("R8 cleared", 72'(stat1), 72'(0));
    @(negedge lclk) begin stat1_set = 8'h42; stat2_set = 8'h81; end
    @(negedge lclk) begin stat1_set = 8'h00; stat2_set = 8'h00; end
    xfer(cmd(1'b1, 0, 1'b1, 2'b00), 11);
    check("R8 burst sees status", 72'({rx[NC], rx[NC+1]}), 72'(16'h4281));
    lwait(10);
    check("R8 burst keeps status", 72'({stat1, stat2}), 72'(16'h4281));
    xfer(cmd(1'b1, NC, 1'b0, 2'b01), 1);
    lwait(10);
    check("R4 void read no clear", 72'(stat1), 72'(8'h42));

    // R9: set held through clear wins
    @(negedge lclk) stat2_set = 8'h01;
    xfer(cmd(1'b1, NC + 1, 1'b0, 2'b00), 1);
    lwait(10);
    check("R9 set beats clear", 72'(stat2), 72'(8'h01));
    @(negedge lclk) stat2_set = 8'h00;
    lwait(2);
    check("R9 sticky", 72'({stat1, stat2}), 72'(16'h4201));

    // R10: reset mid-life
    rst_n = 1'b0; lwait(2);
    check("R10 cfg reset again", 72'(cfg_regs), 72'(0));
    check("R10 stat reset again", 72'({stat1, stat2}), 72'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule